// File: doc/BRIEF.md
# Normally Ready Wait Generator

This block produces an active-high bus READY that is asserted unless a slow device has been selected and needs extra clocks. At each bus-cycle start strobe it reloads an internal shift pattern of zeros and drives READY high. If either of two active-low chip selects is then sampled low, the zeros are shifted out one per rising clock edge. READY stays low while they drain and returns high by itself once ones have filled in behind them.

The wait length is fixed at build time by the zero count. One extra low clock comes from the edge that samples the chip select, so a pattern of N zeros holds READY low for N+1 clocks. Once a wait has begun, it runs to its end regardless of the chip selects. Only a new start strobe cuts it short.

Top module: `wait_ready_gen`

## Requirements
- R1: After reset READY is high, and chip selects driven low before the first start strobe leave it high.
- R2: A start strobe sampled high reloads the zero pattern, and READY is high in the following cycle, even if a wait was in progress.
- R3: If neither chip select is low after a start strobe, READY stays high until the next strobe.
- R4: The first rising edge after a strobe that samples sel_a_ni low, sel_b_ni low, or both low starts a wait. READY is then low from the next cycle for exactly NUM_ZEROS+1 consecutive cycles and high afterwards.
- R5: Releasing the chip select after the wait has begun does not shorten the wait.
- R6: After the pattern is used up, READY stays high until the next strobe, even while a chip select remains low.
- R7: A chip select that is low on the same edge as a start strobe does not start a wait. A wait starts at the next edge that samples it low.
- R8: NUM_ZEROS may be set from 1 to 8, and the wait length follows R4 for each setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_start_i | input | 1 | Bus cycle start strobe, one clock wide |
| sel_a_ni | input | 1 | First chip select, active low |
| sel_b_ni | input | 1 | Second chip select, active low |
| ready_o | output | 1 | Bus ready, active high |

## Verification
The bench builds two instances from the same stimulus. One has NUM_ZEROS=3, the other NUM_ZEROS=1. Comparing them shows that the low window scales with the parameter, and the smaller build covers the shortest pattern, where the shifter is only two stages deep. Each vector measures the length and the onset of the low window for one chip select alone, the other alone, both together, neither, and a select released one clock after it was sampled. Directed cases cover the behaviour before the first strobe and a strobe that arrives mid-wait while a select is held low.

// File: rtl/wait_gen_pkg.sv
package wait_gen_pkg;
  localparam int unsigned MAX_ZEROS = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } wg_state_e;
endpackage

// File: rtl/wait_gen_shifter.sv
module wait_gen_shifter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  output logic top_o
);
  logic [LEN-1:0] sh_q;

  // bit 0 takes the fill value, upper bits take their lower neighbour
  for (genvar i = 0; i < LEN; i++) begin : g_bit
    logic d;
    if (i == 0) begin : g_first
      assign d = 1'b1;
    end else begin : g_rest
      assign d = sh_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q[i] <= 1'b1;
      else if (load_i)  sh_q[i] <= 1'b0;
      else if (shift_i) sh_q[i] <= d;
    end
  end

  assign top_o = sh_q[LEN-1];

  AST_LOAD_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !top_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(top_o)); // R6
endmodule

// File: rtl/wait_gen_ctrl.sv
module wait_gen_ctrl
  import wait_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sel_any_i,
  input  logic done_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o
);
  wg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_ARMED: if (sel_any_i) state_d = ST_WAIT;
        ST_WAIT:  if (done_i)    state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign active_o = (state_q == ST_WAIT);
  assign load_o   = start_i;
  assign shift_o  = active_o && !done_i && !start_i;

  AST_WAIT_FROM_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !$past(active_o)) |-> ($past(state_q) == ST_ARMED && $past(sel_any_i))); // R4
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !$past(start_i)) |-> $past(state_q) == ST_ARMED); // R6
endmodule

// File: rtl/wait_ready_gen.sv
module wait_ready_gen
  import wait_gen_pkg::*;
#(
  parameter int unsigned NUM_ZEROS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_start_i,
  input  logic sel_a_ni,
  input  logic sel_b_ni,
  output logic ready_o
);
  localparam int unsigned LEN = NUM_ZEROS + 1;
  localparam int unsigned CW  = $clog2(LEN + 2);

  logic sel_any, load, shift, active, top;

  assign sel_any = !sel_a_ni || !sel_b_ni;

  wait_gen_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cycle_start_i),
    .sel_any_i (sel_any),
    .done_i    (top),
    .load_o    (load),
    .shift_o   (shift),
    .active_o  (active)
  );

  wait_gen_shifter #(.LEN(LEN)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .top_o   (top)
  );

  assign ready_o = !active || top;

  // consecutive low cycles, for the window checks
  logic [CW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt_q <= '0;
    else if (ready_o) low_cnt_q <= '0;
    else              low_cnt_q <= low_cnt_q + 1'b1;
  end

  AST_START_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> ready_o); // R2
  AST_FALL_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(sel_any)); // R3
  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt_q <= CW'(LEN)); // R4
  AST_FULL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(cycle_start_i)) |-> low_cnt_q == CW'(LEN)); // R5
endmodule

// File: tb/wait_ready_gen_tb_top.sv
module wait_ready_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sel_a_n = 1'b1;
  logic sel_b_n = 1'b1;
  logic rdy3, rdy1;
  int   n_vec = 0;
  int   n_err = 0;

  always #5 clk = ~clk;

  wait_ready_gen #(.NUM_ZEROS(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cycle_start_i(start),
    .sel_a_ni(sel_a_n), .sel_b_ni(sel_b_n), .ready_o(rdy3));

  wait_ready_gen #(.NUM_ZEROS(1)) dut_min_i (
    .clk_i(clk), .rst_ni(rst_n), .cycle_start_i(start),
    .sel_a_ni(sel_a_n), .sel_b_ni(sel_b_n), .ready_o(rdy1));

  typedef struct packed {
    logic       a_n;
    logic       b_n;
    logic [4:0] hold;
    logic [3:0] low3;
    logic [3:0] low1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 5'd20, 4'd0, 4'd0},  // R3 neither
    '{1'b0, 1'b1, 5'd20, 4'd4, 4'd2},  // R4 a alone, R6 held
    '{1'b1, 1'b0, 5'd20, 4'd4, 4'd2},  // R4 b alone
    '{1'b0, 1'b0, 5'd20, 4'd4, 4'd2},  // R4 both
    '{1'b0, 1'b1, 5'd1,  4'd4, 4'd2},  // R5 released early
    '{1'b1, 1'b0, 5'd2,  4'd4, 4'd2}   // R5 released early
  };

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int lows3, lows1, first3, last3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready n3", int'(rdy3), 1);
    check("R1 reset ready n1", int'(rdy1), 1);

    // R1: selects before any strobe are ignored
    sel_a_n = 1'b0; sel_b_n = 1'b0;
    lows3 = 0; lows1 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rdy3) lows3++;
      if (!rdy1) lows1++;
    end
    check("R1 pre-strobe lows n3", lows3, 0);
    check("R1 pre-strobe lows n1", lows1, 0);
    sel_a_n = 1'b1; sel_b_n = 1'b1;

    // vector table: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sel_a_n = VECS[v].a_n;
      sel_b_n = VECS[v].b_n;
      lows3 = 0; lows1 = 0; first3 = -1; last3 = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!rdy3) begin
          lows3++;
          if (first3 < 0) first3 = i;
        end
        if (!rdy1) lows1++;
        last3 = int'(rdy3);
        if (i + 1 >= int'(VECS[v].hold)) begin
          sel_a_n = 1'b1; sel_b_n = 1'b1;
        end
      end
      check($sformatf("R4 vec%0d low n3", v), lows3, int'(VECS[v].low3));
      check($sformatf("R8 vec%0d low n1", v), lows1, int'(VECS[v].low1));
      if (VECS[v].low3 != 0)
        check($sformatf("R4 vec%0d onset", v), first3, 0);
      check($sformatf("R6 vec%0d ready at end", v), last3, 1);
      sel_a_n = 1'b1; sel_b_n = 1'b1;
    end

    // R2 + R7: strobe mid-wait with select held low
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sel_a_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4 mid-wait low", int'(rdy3), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 ready after strobe n3", int'(rdy3), 1);
    check("R2 ready after strobe n1", int'(rdy1), 1);
    lows3 = 0; lows1 = 0; first3 = -1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!rdy3) begin
        lows3++;
        if (first3 < 0) first3 = i;
      end
      if (!rdy1) lows1++;
    end
    check("R7 restart onset", first3, 0);
    check("R7 restart low n3", lows3, 4);
    check("R7 restart low n1", lows1, 2);
    sel_a_n = 1'b1;

    // R7: select low only on the strobe edge
    @(negedge clk);
    start = 1'b1; sel_b_n = 1'b0;
    @(negedge clk);
    start = 1'b0; sel_b_n = 1'b1;
    lows3 = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!rdy3) lows3++;
    end
    check("R7 strobe-edge select ignored", lows3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule